// File: doc/BRIEF.md
# Two-Step Service Watchdog

This block supervises host software by demanding a fixed, ordered pair of register writes on two control bits inside every supervision window. The first write must put bit A high and bit B low; the second must put bit A low and bit B high. Only that exact pair, in that order, restarts the window. If the window elapses without a completed pair, the block drives a reset pulse of fixed length and then begins a new window.

Supervision is live only while a two-bit reset-source select input holds the code 2'b11. Any other code stops the window counter, holds it at zero, drops the half-done state and ends a reset pulse in progress. A sticky flag reports that the watchdog caused the most recent reset; any register write clears it. At the default setting the window is 1,966,080 cycles of the 15.36 MHz oscillator clock (128 ms), and the pulse is 16 cycles.

Top module: `wdt_two_step`

## Requirements
- R1: While the asynchronous reset `rstN` is low, `wdResetOut` and `wdStatus` are both 0.
- R2: With `resetSrcSel` other than 2'b11, `wdResetOut` stays 0 however long the block runs; the window count and the half-done state are cleared, so a second-step write after re-arming does not restart the window.
- R3: Once armed with no service, `wdResetOut` goes high after exactly `WINDOW_CYCLES` rising edges, counting the first edge that samples `resetSrcSel` = 2'b11 as edge 1.
- R4: A reset pulse holds `wdResetOut` high for exactly `PULSE_CYCLES` cycles.
- R5: After a pulse ends, a fresh window starts; without service the next pulse begins `WINDOW_CYCLES + PULSE_CYCLES` edges after the previous one began.
- R6: A write with (`ctrlBit1`,`ctrlBit2`) = (1,0) followed directly by a write with (0,1) restarts the window at the edge that samples the second write.
- R7: Any other pattern does not restart the window: a (0,1) write without a preceding (1,0) write, or a (1,0) write followed by a write of any other value and then (0,1).
- R8: `wdStatus` is set when a pulse starts and cleared by any write; when both happen at the same edge, the set wins.
- R9: A second-step write sampled at the edge where the window would expire restarts the window and no pulse starts.
- R10: Leaving the 2'b11 code during a pulse drops `wdResetOut` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resetSrcSel | input | 2 | Reset-source select; 2'b11 arms the watchdog |
| ctrlWrite | input | 1 | One-cycle strobe of a write to the control bits |
| ctrlBit1 | input | 1 | Control bit A value carried by the write |
| ctrlBit2 | input | 1 | Control bit B value carried by the write |
| wdResetOut | output | 1 | Watchdog reset pulse |
| wdStatus | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
Two pairs of functions can meet in one cycle. A completed service pair whose second write lands on the final cycle of the window collides with expiry; the bench places the second write on that exact edge and judges it by the absence of a pulse and by the next pulse arriving one full window later. A status-clearing write can land on the expiry edge; the bench issues a write there and expects the flag to read 1 afterwards, then 0 after a further write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from the control FSM to the window counter
  typedef struct packed {
    logic cntClear;  // force window count to zero
    logic cntRun;    // advance window count by one
  } wdtStrobes_t;

endpackage

// File: rtl/wdt_window_dp.sv
module wdt_window_dp
  import wdt_pkg::*;
#(
  parameter int WINDOW_CYCLES = 1966080
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdtStrobes_t strobes,
  output logic        atLimit
);

  localparam int CW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.cntClear) begin
      count <= '0;
    end else if (strobes.cntRun) begin
      count <= count + CW'(1);
    end
  end

  assign atLimit = (count == LAST);

  // R3: the window count never runs past its final value
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= LAST);

  // R2: a clear strobe always leaves the count at zero
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntClear |=> (count == '0));

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int PULSE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        armed,
  input  logic        wrStrobe,
  input  logic        bitA,
  input  logic        bitB,
  input  logic        atLimit,
  output wdtStrobes_t strobes,
  output logic        wdResetOut,
  output logic        wdStatus
);

  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYCLES);

  logic          pending;
  logic [PW-1:0] pulseCnt;
  logic          pulsing;
  logic          firstStep;
  logic          secondStep;
  logic          serviceDone;
  logic          expire;

  assign pulsing     = (pulseCnt != '0);
  assign firstStep   = wrStrobe && bitA && !bitB;
  assign secondStep  = wrStrobe && !bitA && bitB;
  assign serviceDone = armed && !pulsing && pending && secondStep;
  assign expire      = armed && !pulsing && atLimit && !serviceDone;

  assign strobes.cntClear = !armed || serviceDone || expire;
  assign strobes.cntRun   = armed && !pulsing;

  // Half-done state: set by a first step, dropped by anything else
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (!armed || pulsing || expire) begin
      pending <= 1'b0;
    end else if (wrStrobe) begin
      pending <= firstStep;
    end
  end

  // Reset pulse length counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (!armed) begin
      pulseCnt <= '0;
    end else if (expire) begin
      pulseCnt <= PULSE_LOAD;
    end else if (pulsing) begin
      pulseCnt <= pulseCnt - PW'(1);
    end
  end

  // Sticky cause flag; expiry wins over a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdStatus <= 1'b0;
    end else if (expire) begin
      wdStatus <= 1'b1;
    end else if (wrStrobe) begin
      wdStatus <= 1'b0;
    end
  end

  assign wdResetOut = pulsing;

  assert_expire_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (wdStatus && wdResetOut));

  assert_disarm_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !wdResetOut);

  assert_disarm_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !pending);

  assert_service_no_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    serviceDone |=> !wdResetOut);

  assert_pulse_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && pulseCnt > PW'(1)) |=> wdResetOut);

endmodule

// File: rtl/wdt_two_step.sv
module wdt_two_step
  import wdt_pkg::*;
#(
  parameter int WINDOW_CYCLES = 1966080,
  parameter int PULSE_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] resetSrcSel,
  input  logic       ctrlWrite,
  input  logic       ctrlBit1,
  input  logic       ctrlBit2,
  output logic       wdResetOut,
  output logic       wdStatus
);

  localparam logic [1:0] ARM_CODE = 2'b11;

  logic        armed;
  logic        atLimit;
  wdtStrobes_t strobes;

  assign armed = (resetSrcSel == ARM_CODE);

  wdt_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .armed      (armed),
    .wrStrobe   (ctrlWrite),
    .bitA       (ctrlBit1),
    .bitB       (ctrlBit2),
    .atLimit    (atLimit),
    .strobes    (strobes),
    .wdResetOut (wdResetOut),
    .wdStatus   (wdStatus)
  );

  wdt_window_dp #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .atLimit (atLimit)
  );

  // R1: outputs quiet while reset is held
  always_comb begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!wdResetOut && !wdStatus);
    end
  end

endmodule

// File: tb/wdt_two_step_test.sv
module wdt_two_step_test;

  localparam int W = 40;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] resetSrcSel = 2'b00;
  logic       ctrlWrite = 1'b0;
  logic       ctrlBit1 = 1'b0;
  logic       ctrlBit2 = 1'b0;
  logic       wdResetOut;
  logic       wdStatus;

  int checks = 0;
  int errors = 0;
  int edgeNo = 0;

  always #2 clk = ~clk;

  wdt_two_step #(.WINDOW_CYCLES(W), .PULSE_CYCLES(P)) uut (
    .clk, .rstN, .resetSrcSel, .ctrlWrite, .ctrlBit1, .ctrlBit2,
    .wdResetOut, .wdStatus
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, edgeNo, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    edgeNo += n;
  endtask

  task automatic doWrite(input logic a, input logic b);
    ctrlWrite = 1'b1; ctrlBit1 = a; ctrlBit2 = b;
    adv(1);
    ctrlWrite = 1'b0; ctrlBit1 = 1'b0; ctrlBit2 = 1'b0;
  endtask

  // Disarm, clear the flag, then arm; next edge is edge 1
  task automatic armFresh();
    resetSrcSel = 2'b00;
    doWrite(1'b0, 1'b0);
    adv(2);
    resetSrcSel = 2'b11;
    edgeNo = 0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    #1;
    check("R1 pulse", wdResetOut, 1'b0);
    check("R1 status", wdStatus, 1'b0);
    adv(2);
    rstN = 1'b1;
    adv(1);
  endtask

  task automatic testWindow();
    armFresh();
    check("R8 flag cleared", wdStatus, 1'b0);
    adv(W - 1);
    check("R3 before expiry", wdResetOut, 1'b0);
    adv(1);
    check("R3 expiry", wdResetOut, 1'b1);
    check("R8 flag set", wdStatus, 1'b1);
    adv(P - 1);
    check("R4 pulse last cycle", wdResetOut, 1'b1);
    adv(1);
    check("R4 pulse ended", wdResetOut, 1'b0);
    adv(W - 1);
    check("R5 before second expiry", wdResetOut, 1'b0);
    adv(1);
    check("R5 second expiry", wdResetOut, 1'b1);
    doWrite(1'b0, 1'b0);
    check("R8 write clears flag", wdStatus, 1'b0);
  endtask

  task automatic testService();
    armFresh();
    adv(W - 11);
    doWrite(1'b1, 1'b0);
    doWrite(1'b0, 1'b1);          // restart at edge W-9
    adv(W - 1);
    check("R6 no pulse after restart", wdResetOut, 1'b0);
    adv(1);
    check("R6 expiry one window after service", wdResetOut, 1'b1);
  endtask

  task automatic testBadOrder();
    armFresh();
    doWrite(1'b0, 1'b1);          // second step alone
    doWrite(1'b1, 1'b0);
    doWrite(1'b1, 1'b1);          // breaks the pair
    doWrite(1'b0, 1'b1);
    adv(W - 5);
    check("R7 before expiry", wdResetOut, 1'b0);
    adv(1);
    check("R7 bad patterns ignored", wdResetOut, 1'b1);
  endtask

  task automatic testFinalEdge();
    armFresh();
    adv(W - 2);
    doWrite(1'b1, 1'b0);
    doWrite(1'b0, 1'b1);          // sampled on expiry edge W
    check("R9 service beats expiry", wdResetOut, 1'b0);
    check("R9 flag stays clear", wdStatus, 1'b0);
    adv(W - 1);
    check("R9 before new expiry", wdResetOut, 1'b0);
    adv(1);
    check("R9 new expiry", wdResetOut, 1'b1);
  endtask

  task automatic testFlagCollide();
    armFresh();
    adv(W - 1);
    doWrite(1'b0, 1'b0);          // write on expiry edge
    check("R8 pulse on collide", wdResetOut, 1'b1);
    check("R8 set wins over clear", wdStatus, 1'b1);
    doWrite(1'b0, 1'b0);
    check("R8 later write clears", wdStatus, 1'b0);
  endtask

  task automatic testDisarm();
    armFresh();
    adv(W);
    check("R10 pulse active", wdResetOut, 1'b1);
    resetSrcSel = 2'b10;
    adv(1);
    check("R10 pulse dropped", wdResetOut, 1'b0);
    for (int i = 0; i < 3 * W; i++) begin
      adv(1);
      if (wdResetOut !== 1'b0) check("R2 disarmed quiet", wdResetOut, 1'b0);
    end
    check("R2 disarmed quiet end", wdResetOut, 1'b0);
    armFresh();
    doWrite(1'b1, 1'b0);          // edge 1: pending set
    resetSrcSel = 2'b01;
    adv(1);                       // edge 2: disarmed, pending cleared
    resetSrcSel = 2'b11;
    adv(1);                       // edge 3: first armed edge again
    doWrite(1'b0, 1'b1);          // must not restart
    adv(W - 3);
    check("R2 before expiry", wdResetOut, 1'b0);
    adv(1);
    check("R2 pending cleared by disarm", wdResetOut, 1'b1);
  endtask

  initial begin
    testReset();
    testWindow();
    testService();
    testBadOrder();
    testFinalEdge();
    testFlagCollide();
    testDisarm();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog timeout: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule